// File: doc/BRIEF.md
# DDR Mode Register and Read-Latency Sequencer

This block sits on the memory side of a double-data-rate SDRAM model. It watches a small command bus and the address bus. A mode-register-set command programs the burst length, the burst ordering and the CAS latency. The operating-mode bits in the same word pick one of three outcomes: normal operation, a DLL reset request, or a reserved combination, which is flagged as an error.

When a READ arrives, the block waits for the programmed latency and then plays out the burst. Each clock carries two beats: one for the rising edge and one for the falling edge. For each beat the block reports the column address. The addresses follow sequential or interleaved order within an aligned window the size of the burst. A burst uses the settings that were in force when its READ was registered. A READ issued while the stored mode is invalid starts nothing and raises a sticky error flag.

Top module: `ddr_mrs_read_seq`

## Requirements
- R1: After synchronous reset the mode is invalid (`mode_bad`=1). The settings read back as burst length 2, sequential order and latency 2. `dll_rst_pulse`, `dll_rst_pend`, `rd_err`, `rd_valid` and `rd_last` are all 0.
- R2: A mode-register-set with addr[10:7]=0000 and legal length and latency codes is accepted. The following fields are loaded: addr[2:0] for length (001=2, 010=4, 011=8 beats), addr[3] for order (0 sequential, 1 interleaved) and addr[6:4] for latency (010=2, 011=3). In the cycle after the command edge, `mode_bad` and `dll_rst_pend` read 0 and the `cfg_*` outputs show the new values.
- R3: A mode-register-set with addr[10:7]=0010 and legal codes loads the same fields. It drives `dll_rst_pulse` high in the cycle after the command edge only. It sets `dll_rst_pend`, which stays high until an accepted normal-mode command.
- R4: A mode-register-set is rejected if addr[10:7] is any value other than 0000 or 0010, or if the length or latency code is not listed in R2. A rejected command sets `mode_bad` and leaves every `cfg_*` output and `dll_rst_pend` unchanged. It gives no `dll_rst_pulse`.
- R5: A READ registered at clock edge n under latency m makes `rd_valid` go high first in the cycle that follows edge n+m.
- R6: A burst of L beats lasts L/2 consecutive cycles. Each cycle carries two beats on `rd_col_rise` and `rd_col_fall`, in that order. `rd_last` marks the final cycle. After that `rd_valid` falls unless another burst is due.
- R7: In sequential order, beat i keeps the column bits above log2(L) from the start column. Its low log2(L) bits are (start + i) mod L.
- R8: In interleaved order, beat i keeps the upper column bits. Its low log2(L) bits are the start column's low bits XOR i.
- R9: A READ issued while `mode_bad` is 1 produces no beats. It sets `rd_err`, which stays set until reset.
- R10: A burst keeps the length and order that were stored when its READ was registered, even if the mode changes while it plays out. A burst whose first beat comes due cuts off any burst still playing, from that cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 2 | Command: 00 idle, 01 mode-register-set, 10 READ, 11 treated as idle |
| addr | input | 11 | Mode word for mode-register-set; start column in the low COL_W bits for READ |
| dll_rst_pulse | output | 1 | One-cycle strobe after an accepted DLL reset request |
| dll_rst_pend | output | 1 | DLL reset requested and not yet followed by a normal-mode command |
| mode_bad | output | 1 | Stored mode is invalid (after reset or after a rejected command) |
| rd_err | output | 1 | Sticky: a READ arrived while the mode was invalid |
| cfg_beats | output | 4 | Stored burst length in beats (2, 4 or 8) |
| cfg_interleave | output | 1 | Stored burst order, 1 for interleaved |
| cfg_cas | output | 2 | Stored read latency in clocks (2 or 3) |
| rd_valid | output | 1 | A pair of read beats is valid this cycle |
| rd_col_rise | output | COL_W | Column address of the rising-edge beat |
| rd_col_fall | output | COL_W | Column address of the falling-edge beat |
| rd_last | output | 1 | This is the final pair of the burst |

## Verification
Some rules are checked on every cycle by the in-line assertions. A rejected mode word must leave the stored settings frozen. An accepted normal-mode word must clear the pending DLL request. The DLL strobe never appears without the pending bit. A READ under an invalid mode must raise the error flag. `rd_last` never shows without `rd_valid`, and the two beats of a pair always share their upper column bits. Other behaviour can only be shown by the bench's scenarios, which compare every output cycle against an independently computed queue. These are the exact cycle of the first beat for each latency, the beat order for every length and ordering, the cut-off when one burst overtakes another, and a burst keeping its settings across a mid-burst mode change.

// File: rtl/ddr_mrs_pkg.sv
package ddr_mrs_pkg;

    // Address bus width of the mode word and field positions within it.
    localparam int MA_W    = 11;
    localparam int BL_LSB  = 0;
    localparam int BT_BIT  = 3;
    localparam int CL_LSB  = 4;
    localparam int OP_LSB  = 7;
    localparam int CL_MAX  = 3;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'b00,
        CMD_MRS   = 2'b01,
        CMD_READ  = 2'b10,
        CMD_SPARE = 2'b11
    } ddr_cmd_e;

    // Encoded as log2 of the burst length.
    typedef enum logic [1:0] {
        BLS_2 = 2'd1,
        BLS_4 = 2'd2,
        BLS_8 = 2'd3
    } bl_sel_e;

    typedef enum logic [1:0] {
        OPK_NORMAL = 2'd0,
        OPK_DLLRST = 2'd1,
        OPK_RSVD   = 2'd2
    } op_kind_e;

    typedef struct packed {
        bl_sel_e bl;
        logic    ilv;
        logic    cl3;
    } mode_cfg_t;

    typedef struct packed {
        logic      ok;
        op_kind_e  op;
        mode_cfg_t cfg;
    } mrs_dec_t;

    function automatic mrs_dec_t decode_mrs(logic [MA_W-1:0] a);
        mrs_dec_t d;
        d.ok      = 1'b1;
        d.cfg.ilv = a[BT_BIT];
        case (a[OP_LSB +: 4])
            4'b0000: d.op = OPK_NORMAL;
            4'b0010: d.op = OPK_DLLRST;
            default: begin
                d.op = OPK_RSVD;
                d.ok = 1'b0;
            end
        endcase
        case (a[BL_LSB +: 3])
            3'b001:  d.cfg.bl = BLS_2;
            3'b010:  d.cfg.bl = BLS_4;
            3'b011:  d.cfg.bl = BLS_8;
            default: begin
                d.cfg.bl = BLS_2;
                d.ok     = 1'b0;
            end
        endcase
        case (a[CL_LSB +: 3])
            3'b010:  d.cfg.cl3 = 1'b0;
            3'b011:  d.cfg.cl3 = 1'b1;
            default: begin
                d.cfg.cl3 = 1'b0;
                d.ok      = 1'b0;
            end
        endcase
        return d;
    endfunction

    function automatic logic [3:0] bl_beats(bl_sel_e b);
        case (b)
            BLS_4:   return 4'd4;
            BLS_8:   return 4'd8;
            default: return 4'd2;
        endcase
    endfunction

    function automatic logic [2:0] bl_mask(bl_sel_e b);
        case (b)
            BLS_4:   return 3'b011;
            BLS_8:   return 3'b111;
            default: return 3'b001;
        endcase
    endfunction

    // Index of the final beat pair of a burst.
    function automatic logic [1:0] bl_last_pair(bl_sel_e b);
        case (b)
            BLS_4:   return 2'd1;
            BLS_8:   return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/ddr_mode_store.sv
module ddr_mode_store
    import ddr_mrs_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            mrs_stb,
    input  logic [MA_W-1:0] mrs_word,
    output mode_cfg_t       cfg,
    output logic            mode_bad,
    output logic            dll_pulse,
    output logic            dll_pend
);

    mrs_dec_t dec;

    always_comb dec = decode_mrs(mrs_word);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg       <= '{bl: BLS_2, ilv: 1'b0, cl3: 1'b0};
            mode_bad  <= 1'b1;
            dll_pulse <= 1'b0;
            dll_pend  <= 1'b0;
        end else begin
            dll_pulse <= 1'b0;
            if (mrs_stb) begin
                if (dec.ok) begin
                    cfg      <= dec.cfg;
                    mode_bad <= 1'b0;
                    if (dec.op == OPK_DLLRST) begin
                        dll_pulse <= 1'b1;
                        dll_pend  <= 1'b1;
                    end else begin
                        dll_pend  <= 1'b0;
                    end
                end else begin
                    mode_bad <= 1'b1;
                end
            end
        end
    end

    AST_REJECT_FREEZES_CFG: assert property (@(posedge clk) disable iff (rst)
        (mrs_stb && !dec.ok) |=> ($stable(cfg) && $stable(dll_pend) && mode_bad && !dll_pulse)); // R4

    AST_NORMAL_CLEARS_PEND: assert property (@(posedge clk) disable iff (rst)
        (mrs_stb && dec.ok && dec.op == OPK_NORMAL) |=> (!dll_pend && !mode_bad)); // R2

    AST_PULSE_WITH_PEND: assert property (@(posedge clk) disable iff (rst)
        dll_pulse |-> dll_pend); // R3

endmodule

// File: rtl/ddr_lat_pipe.sv
module ddr_lat_pipe
    import ddr_mrs_pkg::*;
#(
    parameter int COL_W = 8,
    parameter int DEPTH = CL_MAX
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [COL_W-1:0] push_col,
    input  mode_cfg_t        push_cfg,
    output logic             launch,
    output logic [COL_W-1:0] launch_col,
    output mode_cfg_t        launch_cfg
);

    typedef struct packed {
        logic             vld;
        logic [COL_W-1:0] col;
        mode_cfg_t        cfg;
    } slot_t;

    localparam int SLOT_W = $clog2(DEPTH);

    slot_t            stage [DEPTH];
    slot_t            fresh;
    logic [SLOT_W-1:0] wr_slot;

    // A READ under latency m enters stage m-1 so that stage 0 reaches the
    // burst engine m-1 edges later and its output register m edges later.
    always_comb begin
        fresh   = '{vld: 1'b1, col: push_col, cfg: push_cfg};
        wr_slot = push_cfg.cl3 ? SLOT_W'(2) : SLOT_W'(1);
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == DEPTH - 1) begin : g_top
            always_ff @(posedge clk) begin
                if (rst)                                stage[i] <= '0;
                else if (push && wr_slot == SLOT_W'(i)) stage[i] <= fresh;
                else                                    stage[i] <= '0;
            end
        end else begin : g_mid
            always_ff @(posedge clk) begin
                if (rst)                                stage[i] <= '0;
                else if (push && wr_slot == SLOT_W'(i)) stage[i] <= fresh;
                else                                    stage[i] <= stage[i+1];
            end
        end
    end

    always_comb begin
        launch     = stage[0].vld;
        launch_col = stage[0].col;
        launch_cfg = stage[0].cfg;
    end

endmodule

// File: rtl/ddr_burst_gen.sv
module ddr_burst_gen
    import ddr_mrs_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  mode_cfg_t        start_cfg,
    output logic             rd_valid,
    output logic [COL_W-1:0] rd_col_rise,
    output logic [COL_W-1:0] rd_col_fall,
    output logic             rd_last
);

    localparam int LOW_W = 3;

    logic [COL_W-1:0] base_q;
    mode_cfg_t        cfg_q;
    logic [1:0]       pair_q;

    function automatic logic [COL_W-1:0] beat_col(logic [COL_W-1:0] s,
                                                 logic [LOW_W-1:0] idx,
                                                 mode_cfg_t c);
        logic [LOW_W-1:0] m;
        logic [LOW_W-1:0] lo;
        m  = bl_mask(c.bl);
        lo = c.ilv ? (s[LOW_W-1:0] ^ idx) : (s[LOW_W-1:0] + idx);
        return {s[COL_W-1:LOW_W], (s[LOW_W-1:0] & ~m) | (lo & m)};
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid    <= 1'b0;
            rd_last     <= 1'b0;
            rd_col_rise <= '0;
            rd_col_fall <= '0;
            base_q      <= '0;
            cfg_q       <= '{bl: BLS_2, ilv: 1'b0, cl3: 1'b0};
            pair_q      <= '0;
        end else if (start) begin
            rd_valid    <= 1'b1;
            rd_col_rise <= beat_col(start_col, 3'd0, start_cfg);
            rd_col_fall <= beat_col(start_col, 3'd1, start_cfg);
            rd_last     <= (start_cfg.bl == BLS_2);
            base_q      <= start_col;
            cfg_q       <= start_cfg;
            pair_q      <= 2'd1;
        end else if (rd_valid && !rd_last) begin
            rd_col_rise <= beat_col(base_q, {pair_q, 1'b0}, cfg_q);
            rd_col_fall <= beat_col(base_q, {pair_q, 1'b1}, cfg_q);
            rd_last     <= (pair_q == bl_last_pair(cfg_q.bl));
            pair_q      <= pair_q + 2'd1;
        end else begin
            rd_valid    <= 1'b0;
            rd_last     <= 1'b0;
        end
    end

    AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        rd_last |-> rd_valid); // R6

    AST_PAIR_SHARES_UPPER: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (rd_col_rise[COL_W-1:LOW_W] == rd_col_fall[COL_W-1:LOW_W])); // R7

endmodule

// File: rtl/ddr_mrs_read_seq.sv
module ddr_mrs_read_seq
    import ddr_mrs_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       cmd,
    input  logic [10:0]      addr,
    output logic             dll_rst_pulse,
    output logic             dll_rst_pend,
    output logic             mode_bad,
    output logic             rd_err,
    output logic [3:0]       cfg_beats,
    output logic             cfg_interleave,
    output logic [1:0]       cfg_cas,
    output logic             rd_valid,
    output logic [COL_W-1:0] rd_col_rise,
    output logic [COL_W-1:0] rd_col_fall,
    output logic             rd_last
);

    ddr_cmd_e         cmd_e;
    logic             mrs_stb;
    logic             rd_req;
    logic             rd_go;
    mode_cfg_t        cur_cfg;
    logic             launch;
    logic [COL_W-1:0] launch_col;
    mode_cfg_t        launch_cfg;

    always_comb begin
        cmd_e   = ddr_cmd_e'(cmd);
        mrs_stb = (cmd_e == CMD_MRS);
        rd_req  = (cmd_e == CMD_READ);
        rd_go   = rd_req && !mode_bad;
    end

    ddr_mode_store u_mode (
        .clk       (clk),
        .rst       (rst),
        .mrs_stb   (mrs_stb),
        .mrs_word  (addr),
        .cfg       (cur_cfg),
        .mode_bad  (mode_bad),
        .dll_pulse (dll_rst_pulse),
        .dll_pend  (dll_rst_pend)
    );

    ddr_lat_pipe #(.COL_W(COL_W)) u_pipe (
        .clk        (clk),
        .rst        (rst),
        .push       (rd_go),
        .push_col   (addr[COL_W-1:0]),
        .push_cfg   (cur_cfg),
        .launch     (launch),
        .launch_col (launch_col),
        .launch_cfg (launch_cfg)
    );

    ddr_burst_gen #(.COL_W(COL_W)) u_burst (
        .clk         (clk),
        .rst         (rst),
        .start       (launch),
        .start_col   (launch_col),
        .start_cfg   (launch_cfg),
        .rd_valid    (rd_valid),
        .rd_col_rise (rd_col_rise),
        .rd_col_fall (rd_col_fall),
        .rd_last     (rd_last)
    );

    always_ff @(posedge clk) begin
        if (rst)                      rd_err <= 1'b0;
        else if (rd_req && mode_bad)  rd_err <= 1'b1;
    end

    always_comb begin
        cfg_beats      = bl_beats(cur_cfg.bl);
        cfg_interleave = cur_cfg.ilv;
        cfg_cas        = cur_cfg.cl3 ? 2'd3 : 2'd2;
    end

    AST_BAD_READ_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (rd_req && mode_bad) |=> rd_err); // R9

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        rd_err |=> rd_err); // R9

endmodule

// File: tb/tb_ddr_mrs_read_seq.sv
module tb_ddr_mrs_read_seq;

    localparam int COL_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [1:0]       cmd = 2'b00;
    logic [10:0]      addr = '0;
    logic             dll_rst_pulse, dll_rst_pend, mode_bad, rd_err;
    logic [3:0]       cfg_beats;
    logic             cfg_interleave;
    logic [1:0]       cfg_cas;
    logic             rd_valid, rd_last;
    logic [COL_W-1:0] rd_col_rise, rd_col_fall;

    ddr_mrs_read_seq #(.COL_W(COL_W)) dut (
        .clk(clk), .rst(rst), .cmd(cmd), .addr(addr),
        .dll_rst_pulse(dll_rst_pulse), .dll_rst_pend(dll_rst_pend),
        .mode_bad(mode_bad), .rd_err(rd_err),
        .cfg_beats(cfg_beats), .cfg_interleave(cfg_interleave), .cfg_cas(cfg_cas),
        .rd_valid(rd_valid), .rd_col_rise(rd_col_rise),
        .rd_col_fall(rd_col_fall), .rd_last(rd_last)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int               at;
        logic [COL_W-1:0] r;
        logic [COL_W-1:0] f;
        logic             last;
        string            tag;
    } beat_t;

    beat_t exp_q[$];
    int    total = 0;
    int    bad = 0;
    bit    mon_on = 0;
    bit    done = 0;

    // Bench-side model of the stored mode.
    int m_beats = 2;
    bit m_ilv = 0;
    int m_cl = 2;
    bit m_bad = 1;

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [COL_W-1:0] exp_col(logic [COL_W-1:0] s, int i, int beats, bit ilv);
        logic [COL_W-1:0] mask;
        logic [COL_W-1:0] lo;
        mask = COL_W'(beats - 1);
        lo = ilv ? (s ^ COL_W'(i)) : (s + COL_W'(i));
        return (s & ~mask) | (lo & mask);
    endfunction

    function automatic logic [10:0] mk_mrs(logic [3:0] op, logic [2:0] cl, logic ilv, logic [2:0] bl);
        return {op, cl, ilv, bl};
    endfunction

    task automatic send(logic [1:0] c, logic [10:0] a);
        @(negedge clk);
        cmd  = c;
        addr = a;
        @(negedge clk);
        cmd  = 2'b00;
        addr = '0;
    endtask

    // Accepted-word model update.
    task automatic mrs(logic [3:0] op, logic [2:0] cl, logic ilv, logic [2:0] bl);
        bit ok;
        send(2'b01, mk_mrs(op, cl, ilv, bl));
        ok = (op == 4'b0000 || op == 4'b0010) &&
             (bl == 3'b001 || bl == 3'b010 || bl == 3'b011) &&
             (cl == 3'b010 || cl == 3'b011);
        if (ok) begin
            m_beats = (bl == 3'b001) ? 2 : (bl == 3'b010) ? 4 : 8;
            m_ilv   = ilv;
            m_cl    = (cl == 3'b011) ? 3 : 2;
            m_bad   = 0;
        end else begin
            m_bad = 1;
        end
    endtask

    task automatic read(logic [COL_W-1:0] col);
        int s;
        send(2'b10, {3'b000, col});
        if (m_bad) return;
        s = cyc + m_cl;
        while (exp_q.size() > 0 && exp_q[exp_q.size()-1].at >= s) void'(exp_q.pop_back());
        for (int p = 0; p < m_beats / 2; p++) begin
            beat_t b;
            b.at   = s + p;
            b.r    = exp_col(col, 2 * p, m_beats, m_ilv);
            b.f    = exp_col(col, 2 * p + 1, m_beats, m_ilv);
            b.last = (p == m_beats / 2 - 1);
            b.tag  = m_ilv ? "R5/R6/R8/R10" : "R5/R6/R7/R10";
            exp_q.push_back(b);
        end
    endtask

    task automatic check_cfg(string tag);
        check({tag, " cfg_beats"}, cfg_beats, m_beats);
        check({tag, " cfg_interleave"}, cfg_interleave, m_ilv);
        check({tag, " cfg_cas"}, cfg_cas, m_cl);
        check({tag, " mode_bad"}, mode_bad, m_bad);
    endtask

    // Monitor: pops the scoreboard as beats come due, else expects idle.
    always @(negedge clk) begin
        if (mon_on && !rst) begin
            if (exp_q.size() > 0 && exp_q[0].at == cyc) begin
                beat_t b;
                b = exp_q.pop_front();
                check({b.tag, " rd_valid"}, rd_valid, 1);
                check({b.tag, " rd_col_rise"}, rd_col_rise, b.r);
                check({b.tag, " rd_col_fall"}, rd_col_fall, b.f);
                check({b.tag, " rd_last"}, rd_last, b.last);
            end else begin
                check("R6/R9 idle rd_valid", rd_valid, 0);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [COL_W-1:0] starts [3];
        starts[0] = 8'h00;
        starts[1] = 8'h5B;
        starts[2] = 8'hA6;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check_cfg("R1");
        check("R1 dll_rst_pulse", dll_rst_pulse, 0);
        check("R1 dll_rst_pend", dll_rst_pend, 0);
        check("R1 rd_err", rd_err, 0);
        check("R1 rd_valid", rd_valid, 0);
        check("R1 rd_last", rd_last, 0);
        mon_on = 1;

        // R9: READ before any mode is programmed
        read(8'h12);
        check("R9 rd_err set", rd_err, 1);
        repeat (6) @(negedge clk);

        // R3: DLL reset request, BL4 sequential CL2
        mrs(4'b0010, 3'b010, 1'b0, 3'b010);
        check("R3 dll_rst_pulse high", dll_rst_pulse, 1);
        check("R3 dll_rst_pend", dll_rst_pend, 1);
        check_cfg("R3");
        @(negedge clk);
        check("R3 dll_rst_pulse one cycle", dll_rst_pulse, 0);
        check("R3 dll_rst_pend held", dll_rst_pend, 1);

        // R2 and R5..R8: every length, order and latency
        for (int bi = 1; bi <= 3; bi++) begin
            for (int il = 0; il < 2; il++) begin
                for (int cl = 2; cl <= 3; cl++) begin
                    mrs(4'b0000, 3'(cl), 1'(il), 3'(bi));
                    check_cfg("R2");
                    check("R2 dll_rst_pend cleared", dll_rst_pend, 0);
                    for (int k = 0; k < 3; k++) begin
                        read(starts[k]);
                        repeat (8) @(negedge clk);
                    end
                end
            end
        end

        // R4: reserved operating modes keep settings and pending DLL bit
        mrs(4'b0010, 3'b011, 1'b1, 3'b011);
        @(negedge clk);
        mrs(4'b1000, 3'b010, 1'b0, 3'b001);
        check_cfg("R4 op 1000");
        check("R4 dll_rst_pend kept", dll_rst_pend, 1);
        check("R4 no pulse", dll_rst_pulse, 0);
        mrs(4'b0001, 3'b010, 1'b0, 3'b010);
        check_cfg("R4 op 0001");
        // R9: READ while reserved is ignored
        read(8'h33);
        check("R9 rd_err sticky", rd_err, 1);
        repeat (8) @(negedge clk);
        // R4: reserved latency and length codes with normal op
        mrs(4'b0000, 3'b001, 1'b0, 3'b010);
        check_cfg("R4 cl code 001");
        check("R4 dll_rst_pend kept cl", dll_rst_pend, 1);
        mrs(4'b0000, 3'b010, 1'b0, 3'b100);
        check_cfg("R4 bl code 100");
        check("R4 no pulse bl", dll_rst_pulse, 0);

        // R10: a later burst cuts off an earlier one
        mrs(4'b0000, 3'b010, 1'b0, 3'b011);
        check_cfg("R10 setup");
        read(8'h14);
        read(8'h2D);
        repeat (10) @(negedge clk);

        // R10: mode change mid-burst leaves the running burst alone
        read(8'h47);
        mrs(4'b0000, 3'b010, 1'b1, 3'b001);
        read(8'h63);
        repeat (10) @(negedge clk);

        // R5: latency 3 after latency 2, interleaved BL8
        mrs(4'b0000, 3'b011, 1'b1, 3'b011);
        read(8'hF9);
        repeat (10) @(negedge clk);
        check("R5/R6 queue drained", exp_q.size(), 0);
        check("R9 rd_err still set", rd_err, 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule